// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the operand fields of a memory reference into a 20-bit physical address. It adds a chosen base pointer, a chosen index pointer and a displacement into a 16-bit effective offset. It then picks a 16-bit segment value, shifts it left by four bits and adds the offset. The displacement may be 8 bits, which is sign-extended, or 16 bits. The segment is either the default implied by the pointers in use or an explicit override.

Two string modes address the source element through the source index in the data segment, and the destination element through the destination index in the extra segment. The block also returns the pointer advanced by one element: by one or two bytes, up or down according to the direction flag. A decoder presents one request per clock with `req_valid`. The results appear, registered, on the next clock and hold until the next request.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted, and until the first request after it, `out_valid`, `eff_ofs`, `seg_used`, `phys_addr` and `ptr_next` are all zero.
- R2: Mode 0 (direct) gives an offset equal to the displacement alone; the default segment is DS.
- R3: Mode 1 (register indirect) uses the base pointer if `base_sel` is not 0, otherwise the index pointer. `base_sel` codes are 0 none, 1 BX, 2 BP. `idx_sel` codes are 0 none, 1 SI, 2 DI. The default segment is SS when BP is the base in use and DS in every other case.
- R4: Modes 2 (base+disp) and 3 (index+disp) add the displacement. When `disp_wide`=0 only `disp[7:0]` is used, sign-extended to 16 bits.
- R5: Modes 4 (base+index) and 5 (base+index+disp) add both pointers. With BX=2000h and SI=5400h, the offset is 7400h in mode 4 and 740Fh in mode 5 with displacement 0Fh.
- R6: With `ovr_en`=1 in modes 0 to 6, the segment coded by `ovr_seg` replaces the default. The codes are 0 ES, 1 CS, 2 SS, 3 DS, and `seg_used` reports the segment with the same codes.
- R7: Mode 6 (string source) uses SI as offset and DS as default segment; an override is honoured.
- R8: Mode 7 (string destination) uses DI as offset and always ES; `ovr_en` and `ovr_seg` have no effect.
- R9: In modes 6 and 7, `ptr_next` is the pointer plus the step when `dir_flag`=0 and minus the step when `dir_flag`=1, modulo 2^16. The step is 2 when `word_op`=1 and 1 otherwise. In modes 0 to 5, `ptr_next` equals `eff_ofs`.
- R10: The offset sum wraps modulo 2^16.
- R11: `phys_addr` equals (segment value × 16 + `eff_ofs`) modulo 2^20.
- R12: Results appear one clock after a cycle with `req_valid`=1, with `out_valid`=1. After a cycle with `req_valid`=0, `out_valid` is 0 and the other outputs hold their values.
- R13: When `disp_wide`=1, all 16 displacement bits are added unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe; inputs sampled this cycle |
| mode | input | 3 | Addressing mode code (0..7, see requirements) |
| base_sel | input | 2 | Base pointer choice: 0 none, 1 BX, 2 BP |
| idx_sel | input | 2 | Index pointer choice: 0 none, 1 SI, 2 DI |
| disp | input | 16 | Displacement |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: sign-extended low byte |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment code: 0 ES, 1 CS, 2 SS, 3 DS |
| dir_flag | input | 1 | String direction: 0 up, 1 down |
| word_op | input | 1 | String element size: 0 byte, 1 word |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES segment value |
| seg_cs | input | 16 | CS segment value |
| seg_ss | input | 16 | SS segment value |
| seg_ds | input | 16 | DS segment value |
| out_valid | output | 1 | Result registered from a request |
| eff_ofs | output | 16 | Effective offset |
| seg_used | output | 2 | Segment code chosen |
| phys_addr | output | 20 | Physical address |
| ptr_next | output | 16 | Advanced string pointer, or the offset |

## Verification
The bench applies the worked BX+SI example and a sign-extended negative short displacement. A design that zero-extended the short displacement would land 256 bytes too high. It checks BP-based modes, where a design keyed to the wrong register would address DS instead of SS. It tries overrides in string destination mode, where a leaky mux would steer the store away from ES. Offsets and physical addresses are driven past 64 KB and 1 MB, so a carry that is not dropped shows as a wrong address. All four combinations of direction and element size are stepped, and idle cycles check that outputs hold.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT     = 3'd0,
    AM_INDIRECT   = 3'd1,
    AM_BASE_DISP  = 3'd2,
    AM_IDX_DISP   = 3'd3,
    AM_BASE_IDX   = 3'd4,
    AM_BASE_IDX_D = 3'd5,
    AM_STR_SRC    = 3'd6,
    AM_STR_DST    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    BS_NONE = 2'd0,
    BS_BX   = 2'd1,
    BS_BP   = 2'd2
  } base_e;

  typedef enum logic [1:0] {
    IS_NONE = 2'd0,
    IS_SI   = 2'd1,
    IS_DI   = 2'd2
  } idx_e;

  typedef enum logic [1:0] {
    SG_ES = 2'd0,
    SG_CS = 2'd1,
    SG_SS = 2'd2,
    SG_DS = 2'd3
  } seg_e;

  localparam int unsigned NUM_SEGS = 4;

endpackage

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
  import seg_addr_pkg::*;
#(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       base_sel,
  input  logic [1:0]       idx_sel,
  input  logic [OFS_W-1:0] disp,
  input  logic             disp_wide,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  output logic [OFS_W-1:0] ofs,
  output logic             base_is_bp,
  output logic             is_string
);

  localparam int unsigned EXT_W = OFS_W - SHORT_W;

  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] base_val;
  logic [OFS_W-1:0] idx_val;
  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] idx_term;
  logic [OFS_W-1:0] disp_term;
  logic             use_base;
  logic             use_idx;
  logic             use_disp;

  always_comb begin
    if (disp_wide) begin
      disp_ext = disp;
    end else begin
      disp_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end
  end

  always_comb begin
    case (base_e'(base_sel))
      BS_BX:   base_val = reg_bx;
      BS_BP:   base_val = reg_bp;
      default: base_val = '0;
    endcase
    case (idx_e'(idx_sel))
      IS_SI:   idx_val = reg_si;
      IS_DI:   idx_val = reg_di;
      default: idx_val = '0;
    endcase
  end

  always_comb begin
    use_base  = 1'b0;
    use_idx   = 1'b0;
    use_disp  = 1'b0;
    is_string = 1'b0;
    case (amode_e'(mode))
      AM_DIRECT: use_disp = 1'b1;
      AM_INDIRECT: begin
        use_base = (base_sel != BS_NONE);
        use_idx  = (base_sel == BS_NONE);
      end
      AM_BASE_DISP: begin
        use_base = 1'b1;
        use_disp = 1'b1;
      end
      AM_IDX_DISP: begin
        use_idx  = 1'b1;
        use_disp = 1'b1;
      end
      AM_BASE_IDX: begin
        use_base = 1'b1;
        use_idx  = 1'b1;
      end
      AM_BASE_IDX_D: begin
        use_base = 1'b1;
        use_idx  = 1'b1;
        use_disp = 1'b1;
      end
      default: is_string = 1'b1;
    endcase
  end

  always_comb begin
    base_term  = use_base ? base_val : '0;
    idx_term   = use_idx  ? idx_val  : '0;
    disp_term  = use_disp ? disp_ext : '0;
    base_is_bp = use_base && (base_sel == BS_BP);
    if (is_string) begin
      ofs = (mode == AM_STR_SRC) ? reg_si : reg_di;
    end else begin
      ofs = base_term + idx_term + disp_term;
    end
  end

endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
  import seg_addr_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic [2:0]                      mode,
  input  logic                            base_is_bp,
  input  logic                            ovr_en,
  input  logic [1:0]                      ovr_seg,
  input  logic [NUM_SEGS-1:0][OFS_W-1:0]  seg_bank,
  output logic [1:0]                      seg_code,
  output logic [OFS_W-1:0]                seg_val
);

  logic [1:0] dflt_code;

  always_comb begin
    dflt_code = base_is_bp ? SG_SS : SG_DS;
    if (mode == AM_STR_DST) begin
      seg_code = SG_ES;
    end else if (ovr_en) begin
      seg_code = ovr_seg;
    end else begin
      seg_code = dflt_code;
    end
    seg_val = seg_bank[seg_code];
  end

endmodule

// File: rtl/ea_ptr_step.sv
module ea_ptr_step #(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned STEP_B = 1,
  parameter int unsigned STEP_W = 2
) (
  input  logic [OFS_W-1:0] ptr_in,
  input  logic             dir_down,
  input  logic             word_op,
  output logic [OFS_W-1:0] ptr_out
);

  logic [OFS_W-1:0] step;

  always_comb begin
    step    = word_op ? OFS_W'(STEP_W) : OFS_W'(STEP_B);
    ptr_out = dir_down ? (ptr_in - step) : (ptr_in + step);
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SHORT_W   = 8,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       mode,
  input  logic [1:0]       base_sel,
  input  logic [1:0]       idx_sel,
  input  logic [OFS_W-1:0] disp,
  input  logic             disp_wide,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  input  logic             dir_flag,
  input  logic             word_op,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [OFS_W-1:0] seg_es,
  input  logic [OFS_W-1:0] seg_cs,
  input  logic [OFS_W-1:0] seg_ss,
  input  logic [OFS_W-1:0] seg_ds,
  output logic             out_valid,
  output logic [OFS_W-1:0] eff_ofs,
  output logic [1:0]       seg_used,
  output logic [PA_W-1:0]  phys_addr,
  output logic [OFS_W-1:0] ptr_next
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SEGS-1:0][OFS_W-1:0] seg_bank;
  assign seg_bank[SG_ES] = seg_es;
  assign seg_bank[SG_CS] = seg_cs;
  assign seg_bank[SG_SS] = seg_ss;
  assign seg_bank[SG_DS] = seg_ds;

  logic [OFS_W-1:0] ofs_c;
  logic             base_is_bp_c;
  logic             is_string_c;
  logic [1:0]       seg_code_c;
  logic [OFS_W-1:0] seg_val_c;
  logic [OFS_W-1:0] stepped_c;

  ea_offset_sum #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ofs (
    .mode       (mode),
    .base_sel   (base_sel),
    .idx_sel    (idx_sel),
    .disp       (disp),
    .disp_wide  (disp_wide),
    .reg_bx     (reg_bx),
    .reg_bp     (reg_bp),
    .reg_si     (reg_si),
    .reg_di     (reg_di),
    .ofs        (ofs_c),
    .base_is_bp (base_is_bp_c),
    .is_string  (is_string_c)
  );

  ea_seg_pick #(.OFS_W(OFS_W)) u_seg (
    .mode       (mode),
    .base_is_bp (base_is_bp_c),
    .ovr_en     (ovr_en),
    .ovr_seg    (ovr_seg),
    .seg_bank   (seg_bank),
    .seg_code   (seg_code_c),
    .seg_val    (seg_val_c)
  );

  ea_ptr_step #(.OFS_W(OFS_W)) u_step (
    .ptr_in   (ofs_c),
    .dir_down (dir_flag),
    .word_op  (word_op),
    .ptr_out  (stepped_c)
  );

  // next-state
  logic [PA_W-1:0]  pa_d;
  logic [OFS_W-1:0] ptr_d;
  logic             valid_d;
  logic [OFS_W-1:0] ofs_d;
  logic [1:0]       seg_d;
  logic [PA_W-1:0]  pa_n;
  logic [OFS_W-1:0] ptr_n;

  always_comb begin
    pa_d    = {seg_val_c, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs_c};
    ptr_d   = is_string_c ? stepped_c : ofs_c;
    valid_d = req_valid;
    if (req_valid) begin
      ofs_d = ofs_c;
      seg_d = seg_code_c;
      pa_n  = pa_d;
      ptr_n = ptr_d;
    end else begin
      ofs_d = eff_ofs;
      seg_d = seg_used;
      pa_n  = phys_addr;
      ptr_n = ptr_next;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      eff_ofs   <= '0;
      seg_used  <= '0;
      phys_addr <= '0;
      ptr_next  <= '0;
    end else begin
      out_valid <= valid_d;
      eff_ofs   <= ofs_d;
      seg_used  <= seg_d;
      phys_addr <= pa_n;
      ptr_next  <= ptr_n;
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_addr_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned PA_W     = OFS_W + SEG_SHIFT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       mode,
  input logic [1:0]       base_sel,
  input logic             ovr_en,
  input logic             dir_flag,
  input logic             word_op,
  input logic [OFS_W-1:0] reg_si,
  input logic [OFS_W-1:0] seg_es,
  input logic [OFS_W-1:0] seg_cs,
  input logic [OFS_W-1:0] seg_ss,
  input logic [OFS_W-1:0] seg_ds,
  input logic             out_valid,
  input logic [OFS_W-1:0] eff_ofs,
  input logic [1:0]       seg_used,
  input logic [PA_W-1:0]  phys_addr,
  input logic [OFS_W-1:0] ptr_next
);

  logic [2:0]       live_cnt;
  logic             live;
  logic [OFS_W-1:0] cap_seg [NUM_SEGS];
  logic [OFS_W-1:0] cap_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= '0;
    end else if (live_cnt != 3'd4) begin
      live_cnt <= live_cnt + 3'd1;
    end
  end
  assign live = (live_cnt == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEGS; i++) cap_seg[i] <= '0;
    end else if (req_valid) begin
      cap_seg[SG_ES] <= seg_es;
      cap_seg[SG_CS] <= seg_cs;
      cap_seg[SG_SS] <= seg_ss;
      cap_seg[SG_DS] <= seg_ds;
    end
  end
  assign cap_val = cap_seg[seg_used];

  // R12
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (out_valid == $past(req_valid)));

  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !req_valid) |=> ($stable(eff_ofs) && $stable(phys_addr) && $stable(ptr_next) && $stable(seg_used)));

  // R8
  str_dst_in_es_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && req_valid && mode == AM_STR_DST) |=> (seg_used == SG_ES));

  // R3
  bp_defaults_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && req_valid && !ovr_en && base_sel == BS_BP &&
     (mode == AM_INDIRECT || mode == AM_BASE_DISP || mode == AM_BASE_IDX || mode == AM_BASE_IDX_D))
    |=> (seg_used == SG_SS));

  // R9
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && req_valid && mode == AM_STR_SRC && !dir_flag && word_op)
    |=> (ptr_next == $past(reg_si) + OFS_W'(2)));

  // R11
  phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_valid) |-> (phys_addr == ({cap_val, {SEG_SHIFT{1'b0}}} + PA_W'(eff_ofs))));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .mode      (mode),
  .base_sel  (base_sel),
  .ovr_en    (ovr_en),
  .dir_flag  (dir_flag),
  .word_op   (word_op),
  .reg_si    (reg_si),
  .seg_es    (seg_es),
  .seg_cs    (seg_cs),
  .seg_ss    (seg_ss),
  .seg_ds    (seg_ds),
  .out_valid (out_valid),
  .eff_ofs   (eff_ofs),
  .seg_used  (seg_used),
  .phys_addr (phys_addr),
  .ptr_next  (ptr_next)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  mode;
  logic [1:0]  base_sel, idx_sel, ovr_seg;
  logic [15:0] disp;
  logic        disp_wide, ovr_en, dir_flag, word_op;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        out_valid;
  logic [15:0] eff_ofs, ptr_next;
  logic [1:0]  seg_used;
  logic [19:0] phys_addr;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // expected state
  logic        e_valid;
  logic [15:0] e_ofs, e_ptr;
  logic [1:0]  e_seg;
  logic [19:0] e_pa;

  always #4 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_sel(base_sel), .idx_sel(idx_sel), .disp(disp), .disp_wide(disp_wide),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .dir_flag(dir_flag), .word_op(word_op),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .eff_ofs(eff_ofs), .seg_used(seg_used),
    .phys_addr(phys_addr), .ptr_next(ptr_next)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 0; e_ofs <= 0; e_ptr <= 0; e_seg <= 0; e_pa <= 0;
    end else begin
      e_valid <= req_valid;
      if (req_valid) begin
        int b, x, d, o, s, sv, p;
        bit bp_used;
        b = (base_sel == 1) ? int'(reg_bx) : (base_sel == 2) ? int'(reg_bp) : 0;
        x = (idx_sel == 1) ? int'(reg_si) : (idx_sel == 2) ? int'(reg_di) : 0;
        d = disp_wide ? int'(disp) : ((disp[7] ? -256 : 0) + int'(disp[7:0]));
        bp_used = 0;
        o = 0;
        case (mode)
          0: o = d;
          1: begin o = (base_sel != 0) ? b : x; bp_used = (base_sel == 2); end
          2: begin o = b + d; bp_used = (base_sel == 2); end
          3: o = x + d;
          4: begin o = b + x; bp_used = (base_sel == 2); end
          5: begin o = b + x + d; bp_used = (base_sel == 2); end
          6: o = int'(reg_si);
          default: o = int'(reg_di);
        endcase
        o = ((o % 65536) + 65536) % 65536;
        if (mode == 7) s = 0;
        else if (ovr_en) s = int'(ovr_seg);
        else s = bp_used ? 2 : 3;
        sv = (s == 0) ? int'(seg_es) : (s == 1) ? int'(seg_cs) : (s == 2) ? int'(seg_ss) : int'(seg_ds);
        if (mode >= 6) begin
          p = o + ((dir_flag ? -1 : 1) * (word_op ? 2 : 1));
          p = (p + 65536) % 65536;
        end else p = o;
        e_ofs <= 16'(o);
        e_seg <= 2'(s);
        e_pa  <= 20'((sv * 16 + o) % 1048576);
        e_ptr <= 16'(p);
      end
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #3;
    if (cmp_on) begin
      n_cmp++;
      if (out_valid !== e_valid || eff_ofs !== e_ofs || seg_used !== e_seg ||
          phys_addr !== e_pa || ptr_next !== e_ptr) begin
        n_bad++;
        $display("FAIL %s: got v=%0b ofs=%h seg=%0d pa=%h ptr=%h exp v=%0b ofs=%h seg=%0d pa=%h ptr=%h",
                 tag, out_valid, eff_ofs, seg_used, phys_addr, ptr_next,
                 e_valid, e_ofs, e_seg, e_pa, e_ptr);
      end
    end
  end

  task automatic req(input string t, input logic [2:0] m, input logic [1:0] bs, input logic [1:0] is,
                     input logic [15:0] dv, input logic dw, input logic oe, input logic [1:0] os,
                     input logic df, input logic wo);
    @(negedge clk);
    tag = t; req_valid = 1; mode = m; base_sel = bs; idx_sel = is; disp = dv;
    disp_wide = dw; ovr_en = oe; ovr_seg = os; dir_flag = df; word_op = wo;
  endtask

  task automatic idle(input string t);
    @(negedge clk);
    tag = t; req_valid = 0; mode = 3'd5; base_sel = 2'd2; idx_sel = 2'd2; disp = 16'h1234;
    ovr_en = 1; ovr_seg = 2'd1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; mode = 0; base_sel = 0; idx_sel = 0; disp = 0;
    disp_wide = 0; ovr_en = 0; ovr_seg = 0; dir_flag = 0; word_op = 0;
    reg_bx = 16'h2000; reg_bp = 16'h0100; reg_si = 16'h5400; reg_di = 16'h0200;
    seg_es = 16'h3000; seg_cs = 16'h1000; seg_ss = 16'h4000; seg_ds = 16'h2000;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 0 || eff_ofs !== 0 || seg_used !== 0 || phys_addr !== 0 || ptr_next !== 0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b ofs=%h pa=%h exp all zero", out_valid, eff_ofs, phys_addr);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    idle("R1");
    // R2 direct
    req("R2", 0, 0, 0, 16'h0040, 1, 0, 0, 0, 0);
    // R3 indirect through BX, BP, SI
    req("R3", 1, 1, 0, 16'h0000, 0, 0, 0, 0, 0);
    req("R3", 1, 2, 0, 16'h0000, 0, 0, 0, 0, 0);
    req("R3", 1, 0, 1, 16'h0000, 0, 0, 0, 0, 0);
    // R4 short displacement, negative and positive
    req("R4", 2, 1, 0, 16'h00FE, 0, 0, 0, 0, 0);
    req("R4", 3, 0, 2, 16'hAB7F, 0, 0, 0, 0, 0);
    req("R4", 2, 2, 0, 16'h0080, 0, 0, 0, 0, 0);
    // R5 worked example
    req("R5", 4, 1, 1, 16'h0000, 0, 0, 0, 0, 0);
    req("R5", 5, 1, 1, 16'h000F, 0, 0, 0, 0, 0);
    req("R5", 5, 2, 2, 16'h0010, 0, 0, 0, 0, 0);
    // R13 wide displacement
    req("R13", 2, 1, 0, 16'h80F0, 1, 0, 0, 0, 0);
    // R6 overrides onto every segment
    for (int s = 0; s < 4; s++) req("R6", 2, 2, 0, 16'h0004, 0, 1, 2'(s), 0, 0);
    // R7 string source, plain and overridden
    req("R7", 6, 0, 0, 16'h0000, 0, 0, 0, 0, 0);
    req("R7", 6, 0, 0, 16'h0000, 0, 1, 2'd1, 0, 0);
    // R8 string destination ignores override
    req("R8", 7, 1, 1, 16'h5555, 0, 1, 2'd2, 0, 0);
    req("R8", 7, 2, 2, 16'h0000, 0, 1, 2'd3, 0, 0);
    // R9 steps, all direction/size combos
    for (int k = 0; k < 4; k++) req("R9", 6, 0, 0, 0, 0, 0, 0, k[1], k[0]);
    for (int k = 0; k < 4; k++) req("R9", 7, 0, 0, 0, 0, 0, 0, k[1], k[0]);
    // R12 hold across idle
    idle("R12"); idle("R12");
    // R10 offset wrap and pointer wrap
    @(negedge clk); reg_bx = 16'hFFFF; reg_si = 16'hFFFF; reg_di = 16'h0000;
    req("R10", 2, 1, 0, 16'h0002, 0, 0, 0, 0, 0);
    req("R10", 5, 1, 1, 16'hFFFF, 1, 0, 0, 0, 0);
    req("R10", 6, 0, 0, 0, 0, 0, 0, 0, 1);
    req("R10", 7, 0, 0, 0, 0, 0, 0, 1, 1);
    // R11 physical wrap past 1 MB
    @(negedge clk); seg_ds = 16'hFFFF; seg_ss = 16'hF000; reg_bx = 16'h0020;
    req("R11", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    req("R11", 0, 0, 0, 16'hFFFF, 1, 1, 2'd2, 0, 0);
    // sweep of pointer patterns
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      reg_bx = 16'(i * 16'h0731); reg_bp = 16'(i * 16'h1F03);
      reg_si = 16'(16'hF000 + i * 16'h0111); reg_di = 16'(i * 16'h2203);
      req("R5", 3'(i % 8), 2'(i % 3), 2'((i / 3) % 3), 16'(i * 16'h0457), i[0], i[2], 2'(i), i[1], i[3]);
    end
    idle("R12"); idle("R12");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule